// File: doc/BRIEF.md
# Associative Variable Store with Stack Generations

This block is a small content-addressed store for program variables. Each slot holds a three-part key, a data word and a descriptor. The key parts are a generation number, a name and an index. The descriptor parts are a bit length, a pointer and a free user field. A client reaches a slot by key, not by address. Any key part may be excluded from the comparison. Masking the index this way reaches every element of a vector at once. Masking all parts reaches the whole store.

Stacks live in the same slots. A stack is just the set of live slots that share one name. Generation 0 is the newest element, and larger generations are older. A push stores a new slot at generation 0 and ages every other slot of that name by one, in the same clock. A pop returns and frees the generation-0 slot and makes every remaining slot of that name one generation younger, also in the same clock. To read or write the top without moving the stack, an ordinary access is made with generation 0 and the stack's name.

All commands complete in one cycle. The response is registered and appears on the clock edge that accepts the command.

Top module: `assoc_store`

## Requirements
- R1: After reset the store holds no live slot, and every response output is 0.
- R2: `cmd_op` is coded as 0 idle, 1 read, 2 write, 3 push and 4 pop. `cmd_care` bit 0 compares the generation, bit 1 compares the name and bit 2 compares the index. A key part whose care bit is 0 is ignored. A read returns the data and descriptor of a live matching slot and sets `rsp_hit`. If no live slot matches, the read sets `rsp_miss` instead.
- R3: When more than one live slot matches, the lowest-numbered slot is returned and `rsp_multi` is set.
- R4: A write replaces the data and descriptor of every live matching slot. If nothing matches, it fills the lowest free slot with the full command key. If nothing matches and no slot is free, it sets `rsp_full` and changes nothing.
- R5: A push stores the command's index, data and descriptor at generation 0 in the lowest free slot. In the same cycle it adds 1 to the generation of every other live slot with that name. The new slot itself is not aged.
- R6: A push with no free slot sets `rsp_full` and leaves all slots unchanged.
- R7: A pop returns the lowest live slot with the command's name at generation 0 and frees it. In the same cycle it subtracts 1 from every remaining slot of that name whose generation is above 0. No generation ever goes below 0.
- R8: A pop that finds no generation-0 slot under the name sets `rsp_miss` and changes nothing.
- R9: `rsp_valid` is 1 in the cycle after a non-idle command and 0 after an idle one. `rsp_data` and the descriptor outputs are 0 for write and push.
- R10: A push or pop leaves every slot of any other name untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command code |
| cmd_care | input | 3 | Per-key-part compare enables |
| cmd_gen | input | GEN_W | Generation part of the key |
| cmd_name | input | NAME_W | Name part of the key |
| cmd_idx | input | IDX_W | Index part of the key |
| cmd_data | input | DATA_W | Data word to store |
| cmd_len | input | LEN_W | Descriptor bit length to store |
| cmd_ptr | input | PTR_W | Descriptor pointer to store |
| cmd_aux | input | AUX_W | Descriptor user field to store |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A live slot matched |
| rsp_miss | output | 1 | Read or pop found no slot |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_full | output | 1 | No free slot for the new entry |
| rsp_data | output | DATA_W | Data of the returned slot |
| rsp_len | output | LEN_W | Bit length of the returned slot |
| rsp_ptr | output | PTR_W | Pointer of the returned slot |
| rsp_aux | output | AUX_W | User field of the returned slot |

## Verification
Two functions must share one cycle without interfering. A push allocates a slot while every other slot of the same name is aged. A pop frees the top slot while its siblings are made younger. The bench provokes both on stacks that already hold several elements, next to other names and vectors. It also pushes into a completely full store, and pops a name that holds two generation-0 slots. After each command it reads individual generations back through the port, and a behavioural model checks the results on every clock. If a slot was aged twice, a new slot was aged, or a sibling wrapped below 0, the model shows a wrong slot or a miss.

// File: rtl/assoc_store.sv
module assoc_store #(
  parameter int ENTRIES = 8,
  parameter int GEN_W   = 4,
  parameter int NAME_W  = 8,
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 6,
  parameter int PTR_W   = 6,
  parameter int AUX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [2:0]        cmd_care,
  input  logic [GEN_W-1:0]  cmd_gen,
  input  logic [NAME_W-1:0] cmd_name,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [AUX_W-1:0]  cmd_aux,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_multi,
  output logic              rsp_full,
  output logic [DATA_W-1:0] rsp_data,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [PTR_W-1:0]  rsp_ptr,
  output logic [AUX_W-1:0]  rsp_aux
);
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [2:0] OP_READ = 3'd1, OP_WRITE = 3'd2, OP_PUSH = 3'd3, OP_POP = 3'd4;

  logic [ENTRIES-1:0] live_q;
  logic [GEN_W-1:0]   gen_q  [ENTRIES];
  logic [NAME_W-1:0]  name_q [ENTRIES];
  logic [IDX_W-1:0]   idx_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [LEN_W-1:0]   len_q  [ENTRIES];
  logic [PTR_W-1:0]   ptr_q  [ENTRIES];
  logic [AUX_W-1:0]   aux_q  [ENTRIES];

  logic [ENTRIES-1:0] key_hit, same_name, top_hit, pick;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign same_name[e] = live_q[e] && (name_q[e] == cmd_name);
    assign top_hit[e]   = same_name[e] && (gen_q[e] == '0);
    assign key_hit[e]   = live_q[e]
                        && (!cmd_care[0] || gen_q[e]  == cmd_gen)
                        && (!cmd_care[1] || name_q[e] == cmd_name)
                        && (!cmd_care[2] || idx_q[e]  == cmd_idx);
  end

  assign pick = (cmd_op == OP_POP) ? top_hit : key_hit;

  logic              pick_any, pick_many, free_any;
  logic [SLOT_W-1:0] pick_slot, free_slot;

  always_comb begin
    pick_any  = 1'b0;
    pick_many = 1'b0;
    pick_slot = '0;
    free_any  = 1'b0;
    free_slot = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (pick[e]) begin
        if (pick_any) pick_many = 1'b1;
        else begin
          pick_any  = 1'b1;
          pick_slot = SLOT_W'(e);
        end
      end
      if (!live_q[e] && !free_any) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(e);
      end
    end
  end

  wire is_read  = (cmd_op == OP_READ);
  wire is_write = (cmd_op == OP_WRITE);
  wire is_push  = (cmd_op == OP_PUSH);
  wire is_pop   = (cmd_op == OP_POP);
  wire returns  = is_read || is_pop;
  wire do_alloc = (is_write && !pick_any && free_any) || (is_push && free_any);
  wire do_pop   = is_pop && pick_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_full  <= 1'b0;
      rsp_data  <= '0;
      rsp_len   <= '0;
      rsp_ptr   <= '0;
      rsp_aux   <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        gen_q[e]  <= '0;
        name_q[e] <= '0;
        idx_q[e]  <= '0;
        data_q[e] <= '0;
        len_q[e]  <= '0;
        ptr_q[e]  <= '0;
        aux_q[e]  <= '0;
      end
    end else begin
      rsp_valid <= (cmd_op != 3'd0);
      rsp_hit   <= (returns || is_write) && pick_any;
      rsp_multi <= (returns || is_write) && pick_many;
      rsp_miss  <= returns && !pick_any;
      rsp_full  <= !free_any && (is_push || (is_write && !pick_any));
      rsp_data  <= (returns && pick_any) ? data_q[pick_slot] : '0;
      rsp_len   <= (returns && pick_any) ? len_q[pick_slot]  : '0;
      rsp_ptr   <= (returns && pick_any) ? ptr_q[pick_slot]  : '0;
      rsp_aux   <= (returns && pick_any) ? aux_q[pick_slot]  : '0;

      for (int e = 0; e < ENTRIES; e++) begin
        if (is_write && key_hit[e]) begin
          data_q[e] <= cmd_data;
          len_q[e]  <= cmd_len;
          ptr_q[e]  <= cmd_ptr;
          aux_q[e]  <= cmd_aux;
        end
        if (do_alloc && SLOT_W'(e) == free_slot) begin
          live_q[e] <= 1'b1;
          gen_q[e]  <= is_push ? '0 : cmd_gen;
          name_q[e] <= cmd_name;
          idx_q[e]  <= cmd_idx;
          data_q[e] <= cmd_data;
          len_q[e]  <= cmd_len;
          ptr_q[e]  <= cmd_ptr;
          aux_q[e]  <= cmd_aux;
        end
        if (is_push && free_any && same_name[e])
          gen_q[e] <= gen_q[e] + 1'b1;
        if (do_pop) begin
          if (SLOT_W'(e) == pick_slot)
            live_q[e] <= 1'b0;
          else if (same_name[e] && gen_q[e] != '0)
            gen_q[e] <= gen_q[e] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/assoc_store_checks.sv
module assoc_store_checks #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         cmd_op,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_multi,
  input logic               rsp_full,
  input logic [ENTRIES-1:0] live_q
);
  p_valid_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 3'd0) |=> rsp_valid);

  p_quiet_after_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd0) |=> !rsp_valid);

  p_hit_miss_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));

  p_multi_has_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);

  p_push_adds_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd3 && !(&live_q)) |=> ($countones(live_q) == $past($countones(live_q)) + 1));

  p_full_push_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd3 && (&live_q)) |=> (rsp_full && $stable(live_q)));

  p_pop_frees_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd4) |=> ($countones(live_q) == $past($countones(live_q)) - (rsp_hit ? 1 : 0)));
endmodule

bind assoc_store assoc_store_checks #(.ENTRIES(ENTRIES)) u_checks (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_multi(rsp_multi),
  .rsp_full(rsp_full), .live_q(live_q)
);

// File: tb/assoc_store_bench.sv
`timescale 1ns/1ps
module assoc_store_bench;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd_op = '0, cmd_care = '0;
  logic [3:0] cmd_gen = '0;
  logic [7:0] cmd_name = '0, cmd_idx = '0;
  logic [15:0] cmd_data = '0;
  logic [5:0] cmd_len = '0, cmd_ptr = '0;
  logic [3:0] cmd_aux = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_full;
  logic [15:0] rsp_data;
  logic [5:0] rsp_len, rsp_ptr;
  logic [3:0] rsp_aux;

  always #2 clk = ~clk;

  assoc_store u_assoc_store (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_care(cmd_care),
    .cmd_gen(cmd_gen), .cmd_name(cmd_name), .cmd_idx(cmd_idx),
    .cmd_data(cmd_data), .cmd_len(cmd_len), .cmd_ptr(cmd_ptr), .cmd_aux(cmd_aux),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_multi(rsp_multi), .rsp_full(rsp_full), .rsp_data(rsp_data),
    .rsp_len(rsp_len), .rsp_ptr(rsp_ptr), .rsp_aux(rsp_aux)
  );

  int checks = 0, errors = 0;
  bit m_live [N];
  int m_gen [N], m_name [N], m_idx [N], m_data [N], m_len [N], m_ptr [N], m_aux [N];
  logic [50:0] expv;

  function automatic bit fits(int e, int op, int care, int g, int nm, int ix);
    if (!m_live[e]) return 0;
    if (op == 4) return m_name[e] == nm && m_gen[e] == 0;
    return (!care[0] || m_gen[e] == g) && (!care[1] || m_name[e] == nm) && (!care[2] || m_idx[e] == ix);
  endfunction

  task automatic model(int op, int care, int g, int nm, int ix, int d, int l, int p, int a);
    int first = -1, cnt = 0, fr = -1;
    bit h = 0, ms = 0, mu = 0, fu = 0;
    int od = 0, ol = 0, opt = 0, oa = 0;
    for (int e = 0; e < N; e++) begin
      if (op != 0 && fits(e, op, care, g, nm, ix)) begin
        cnt++;
        if (first < 0) first = e;
      end
      if (!m_live[e] && fr < 0) fr = e;
    end
    if (op == 1 || op == 4) begin
      h = cnt > 0; ms = cnt == 0; mu = cnt > 1;
      if (h) begin od = m_data[first]; ol = m_len[first]; opt = m_ptr[first]; oa = m_aux[first]; end
    end
    if (op == 2) begin
      h = cnt > 0; mu = cnt > 1;
      if (h) begin
        for (int e = 0; e < N; e++)
          if (fits(e, op, care, g, nm, ix)) begin m_data[e] = d; m_len[e] = l; m_ptr[e] = p; m_aux[e] = a; end
      end else if (fr < 0) fu = 1;
      else begin
        m_live[fr] = 1; m_gen[fr] = g; m_name[fr] = nm; m_idx[fr] = ix;
        m_data[fr] = d; m_len[fr] = l; m_ptr[fr] = p; m_aux[fr] = a;
      end
    end
    if (op == 3) begin
      if (fr < 0) fu = 1;
      else begin
        for (int e = 0; e < N; e++) if (m_live[e] && m_name[e] == nm) m_gen[e]++;
        m_live[fr] = 1; m_gen[fr] = 0; m_name[fr] = nm; m_idx[fr] = ix;
        m_data[fr] = d; m_len[fr] = l; m_ptr[fr] = p; m_aux[fr] = a;
      end
    end
    if (op == 4 && first >= 0) begin
      m_live[first] = 0;
      for (int e = 0; e < N; e++) if (m_live[e] && m_name[e] == nm && m_gen[e] > 0) m_gen[e]--;
    end
    expv = {op != 0, h, ms, mu, fu, 16'(od), 6'(ol), 6'(opt), 4'(oa)};
  endtask

  task automatic step(string tag, int op, int care, int g, int nm, int ix, int d = 0);
    logic [50:0] act;
    @(negedge clk);
    cmd_op = 3'(op); cmd_care = 3'(care); cmd_gen = 4'(g); cmd_name = 8'(nm); cmd_idx = 8'(ix);
    cmd_data = 16'(d); cmd_len = 6'(d + 1); cmd_ptr = 6'(d + 2); cmd_aux = 4'(d + 3);
    model(op, care, g, nm, ix, d, d + 1, d + 2, d + 3);
    @(posedge clk); #1;
    act = {rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_full, rsp_data, rsp_len, rsp_ptr, rsp_aux};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < N; e++) m_live[e] = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_full, rsp_data} !== '0) begin
      errors++; $display("FAIL R1: got %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    step("R1", 1, 3'b010, 0, 5, 0);
    step("R9", 0, 0, 0, 0, 0);
    step("R4", 2, 3'b111, 0, 10, 0, 100);
    step("R2", 1, 3'b110, 9, 10, 0);
    step("R4", 2, 3'b111, 0, 20, 1, 201);
    step("R4", 2, 3'b111, 0, 20, 2, 202);
    step("R4", 2, 3'b111, 0, 20, 3, 203);
    step("R2", 1, 3'b110, 0, 20, 2);
    step("R2", 1, 3'b110, 0, 20, 7);
    step("R3", 1, 3'b010, 0, 20, 0);
    step("R2", 1, 3'b000, 0, 0, 0);
    step("R4", 2, 3'b010, 0, 20, 0, 85);
    step("R4", 1, 3'b110, 0, 20, 3);
    step("R5", 3, 0, 0, 30, 1, 11);
    step("R5", 3, 0, 0, 30, 2, 12);
    step("R5", 3, 0, 0, 30, 3, 13);
    step("R5", 1, 3'b011, 0, 30, 0);
    step("R5", 1, 3'b011, 2, 30, 0);
    step("R10", 1, 3'b110, 0, 10, 0);
    step("R7", 4, 0, 0, 30, 0);
    step("R7", 1, 3'b011, 1, 30, 0);
    step("R7", 4, 0, 0, 30, 0);
    step("R7", 1, 3'b011, 0, 30, 0);
    step("R5", 3, 0, 0, 40, 1, 41);
    step("R5", 3, 0, 0, 40, 2, 42);
    step("R5", 3, 0, 0, 40, 3, 43);
    step("R6", 3, 0, 0, 40, 4, 44);
    step("R6", 1, 3'b011, 0, 40, 0);
    step("R6", 1, 3'b011, 3, 40, 0);
    step("R4", 2, 3'b111, 0, 77, 0, 7);
    step("R10", 1, 3'b011, 0, 30, 0);
    step("R7", 4, 0, 0, 30, 0);
    step("R8", 4, 0, 0, 30, 0);
    step("R8", 4, 0, 0, 99, 0);
    step("R10", 1, 3'b011, 2, 40, 0);
    step("R4", 2, 3'b111, 0, 50, 1, 51);
    step("R6", 4, 0, 0, 40, 0);
    step("R4", 2, 3'b111, 0, 50, 2, 52);
    step("R3", 4, 0, 0, 50, 0);
    step("R7", 1, 3'b011, 0, 50, 0);
    step("R7", 4, 0, 0, 50, 0);
    step("R8", 4, 0, 0, 50, 0);
    step("R7", 1, 3'b011, 0, 40, 0);
    step("R9", 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule